// File: doc/BRIEF.md
# Serial Pattern Recognizer with Lockout

This block watches a serial bit stream, taking at most one bit per clock when its valid strobe is high. It raises a one-bit detect output when the two most recent accepted bits were a 1 and then a 0, in that order. It is a Moore machine, so the output follows from the stored state alone and appears in the cycle after the bit that completes the pair.

A run of three accepted 1s in a row is treated as a fault signature. It moves the machine into an absorbing lockout state, and from then on detection is suppressed until reset. Cycles with the strobe low are not part of the stream. The machine holds its state through them and ignores the data pin.

Top module: `serial_pattern_lock`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the machine returns to its idle state. `det_o` reads 0 after that edge, and any lockout is cleared.
- R2: When the machine is not locked and the last two accepted bits were 1 and then 0, `det_o` is 1 in the cycle that follows the edge accepting the 0.
- R3: When the machine is not locked, `det_o` is 0 in every other case. This includes directly after reset, after a single accepted bit, and after any accepted 1.
- R4: Three consecutive accepted 1s force `det_o` to 0 and lock the machine. Every later input sequence, valid or not, keeps `det_o` at 0 until the next reset.
- R5: A cycle with `bit_vld` low leaves the state unchanged, and the value on `bit_in` has no effect. `det_o` keeps its value, and later behaviour matches a stream in which that cycle never happened.
- R6: A run of 1s is broken only by an accepted 0. Two 1s followed by a 0 give a detection with no lockout. A 1 accepted right after a detection starts a new run, so "1 1 0 1 1 1" ends in lockout.
- R7: A reset after lockout restores normal detection: a following "1 0" gives `det_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| det_o | output | 1 | High when the last two accepted bits were 1 then 0 and the machine is not locked |

## Verification
The assertions assume that `bit_vld` and `bit_in` are known and change only away from the rising edge, and that reset is held low for at least one edge before checking starts. The bench drives every input on the falling edge and holds reset low from time zero. It mixes seeded random streams with random valid gaps and occasional resets. Directed runs cover lockout entry, the boundary of a run of two ones, and gaps inserted in the middle of patterns.

// File: rtl/spl_pkg.sv
// Package: shared state type for the serial pattern recognizer.
// Assumes a single clock domain; encodings 5..7 are unused.
package spl_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,   // reset, or last accepted bit was 0 with no pending match
        ST_ONE  = 3'd1,   // run of one 1
        ST_TWO  = 3'd2,   // run of two 1s
        ST_TEN  = 3'd3,   // last two accepted bits were 1 then 0
        ST_LOCK = 3'd4    // absorbing lockout after three 1s
    } spl_state_e;
endpackage

// File: rtl/spl_next_state.sv
// Module: next-state logic for the recognizer.
// Pure combinational logic. Assumes bit_in is meaningful only when bit_vld is high.
module spl_next_state
    import spl_pkg::*;
(
    input  spl_state_e cur_st,
    input  logic       bit_vld,
    input  logic       bit_in,
    output spl_state_e nxt_st
);
    // Purpose: choose the following state from the current state and the accepted bit.
    always_comb begin
        nxt_st = cur_st;
        if (bit_vld) begin
            unique case (cur_st)
                ST_IDLE: nxt_st = bit_in ? ST_ONE  : ST_IDLE;
                ST_ONE:  nxt_st = bit_in ? ST_TWO  : ST_TEN;
                ST_TWO:  nxt_st = bit_in ? ST_LOCK : ST_TEN;
                ST_TEN:  nxt_st = bit_in ? ST_ONE  : ST_IDLE;
                ST_LOCK: nxt_st = ST_LOCK;
                default: nxt_st = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spl_out_decode.sv
// Module: Moore output decode. The output depends on the state alone.
// Assumes the state input comes straight from a register.
module spl_out_decode
    import spl_pkg::*;
(
    input  spl_state_e cur_st,
    output logic       det
);
    // Purpose: flag the 1-then-0 state.
    always_comb begin
        det = (cur_st == ST_TEN);
    end
endmodule

// File: rtl/serial_pattern_lock.sv
// Module: top of the serial 1-then-0 recognizer with a lockout after three 1s.
// Assumes synchronous active-low reset and inputs that are stable around the rising edge.
module serial_pattern_lock
    import spl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic det_o
);
    spl_state_e state_q;
    spl_state_e state_d;

    spl_next_state u_nxt (
        .cur_st  (state_q),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .nxt_st  (state_d)
    );

    // Purpose: hold the state, with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    spl_out_decode u_dec (
        .cur_st (state_q),
        .det    (det_o)
    );
endmodule

// File: rtl/spl_checker.sv
// Module: property checker for serial_pattern_lock, attached by bind.
// Assumes inputs are known at every rising edge after reset has been applied.
module spl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_vld,
    input logic       bit_in,
    input logic       det_o,
    input logic [2:0] state
);
    // R1
    rst_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!det_o && state == 3'd0));

    // R2
    det_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_o) |-> $past(bit_vld && !bit_in));

    // R3
    no_det_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in) |=> !det_o);

    // R4
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4) |=> (state == 3'd4));

    // R4
    lock_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd4) |-> !det_o);

    // R5
    gap_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(state) && $stable(det_o)));
endmodule

bind serial_pattern_lock spl_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .det_o   (det_o),
    .state   (state_q)
);

// File: tb/tb_serial_pattern_lock.sv
module tb_serial_pattern_lock;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic det_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int  run_len;
    bit  locked;
    bit  last_b, prev_b;
    int  nbits;

    serial_pattern_lock dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .det_o(det_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic model_det();
        return (!locked && nbits >= 2 && prev_b && !last_b);
    endfunction

    task automatic model_reset();
        run_len = 0; locked = 0; last_b = 0; prev_b = 0; nbits = 0;
    endtask

    task automatic model_bit(input bit b);
        if (!locked) begin
            run_len = b ? run_len + 1 : 0;
            if (run_len >= 3) locked = 1;
            prev_b = last_b;
            last_b = b;
            if (nbits < 2) nbits++;
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: det_o actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive on the falling edge, then sample at the next falling edge
    task automatic step(input bit v, input bit b);
        bit_vld = v; bit_in = b;
        @(posedge clk);
        if (!rst_n) model_reset();
        else if (v) model_bit(b);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic feed(input string req, input bit b);
        step(1'b1, b);
        check(req, det_o, model_det());
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        check("R1", det_o, 1'b0);

        // R2: plain 1 then 0
        feed("R3", 1); check("R3", det_o, 1'b0);
        feed("R2", 0); check("R2", det_o, 1'b1);
        feed("R3", 0); check("R3", det_o, 1'b0);

        // R6: two ones then zero detects without lockout
        feed("R6", 1); feed("R6", 1); feed("R6", 0);
        check("R6", det_o, 1'b1);
        // R6: 1 1 0 1 1 1 locks
        feed("R6", 1); feed("R6", 1); feed("R6", 1);
        feed("R4", 0); check("R4", det_o, 1'b0);
        feed("R4", 1); feed("R4", 0); check("R4", det_o, 1'b0);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, i[0]);
            check("R4", det_o, 1'b0);
        end

        // R7: reset clears lockout
        do_reset();
        check("R1", det_o, 1'b0);
        feed("R7", 1); feed("R7", 0); check("R7", det_o, 1'b1);

        // R5: a gap with data 1 during a match keeps det high
        step(1'b0, 1'b1); check("R5", det_o, 1'b1);
        step(1'b0, 1'b0); check("R5", det_o, 1'b1);
        // R5: gap between the 1 and the 0 is transparent
        feed("R5", 1);
        step(1'b0, 1'b0); check("R5", det_o, 1'b0);
        feed("R5", 0); check("R5", det_o, 1'b1);
        // R5: gaps with 1s do not extend a run
        feed("R5", 1); feed("R5", 1);
        step(1'b0, 1'b1); step(1'b0, 1'b1);
        feed("R5", 0); check("R5", det_o, 1'b1);

        // random traffic with occasional resets
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 150) == 0) begin
                do_reset();
                check("R1", det_o, 1'b0);
            end else begin
                bit v, b;
                v = (($urandom % 4) != 0);
                b = (($urandom % 5) < 3);
                step(v, b);
                if (locked) check("R4", det_o, model_det());
                else if (!v) check("R5", det_o, model_det());
                else if (model_det()) check("R2", det_o, model_det());
                else check("R3", det_o, model_det());
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule